// File: doc/BRIEF.md
# Armed Mission Memory Clear Controller

This block wipes a logger's mission state, but only after software has deliberately armed it. A serial command front end hands it decoded memory-function command codes, one per cycle, each flagged by a valid strobe. Software sets an arm bit through a control register write. The erase starts only if the clear command arrives as the very next memory-function command after arming. Any other valid command drops the arm bit first, so a stray or reordered command sequence can never wipe a mission.

Once started, the erase sequencer cannot be stopped. It walks three address regions in a fixed order, one address per cycle, writing zeros through a dedicated write port. The three regions are the mission configuration registers (sample rate, start delay, timestamp and sample counter), the alarm memory and the histogram memory. A hold-off counter then stretches the run to a fixed total length in cycles. Because the erase has its own port, ordinary reads and writes elsewhere in the memory map continue alongside it without arbitration. When the run ends, a status flag reports that memory is cleared and the arm bit reads zero.

Top module: `mission_clear_ctrl`

## Requirements
- R1: After reset the arm bit, the cleared flag, the busy flag and the erase write strobe are all 0.
- R2: While idle, a control write with the arm input at 1 sets the arm bit and clears the cleared flag on the next cycle. A control write with the arm input at 0 clears the arm bit. While busy, control writes are ignored and the arm bit stays 0.
- R3: A valid command with code 0x3C, accepted while the arm bit is 1 and the block is idle, raises busy and clears the arm bit on the next cycle.
- R4: A 0x3C command while the arm bit is 0 starts nothing.
- R5: A valid command with any code other than 0x3C clears the arm bit on the next cycle, so a later 0x3C does not start an erase. A control write in the same cycle as such a command decides the arm bit instead.
- R6: During a run, the erase port writes zero data to ascending addresses, one per cycle, starting in the first busy cycle. It covers REG_LEN addresses from REG_BASE, then ALM_LEN from ALM_BASE, then HIS_LEN from HIS_BASE, and issues no other writes.
- R7: Busy stays high for exactly CLR_CYCLES cycles. No command, clear command or control write during the run shortens or restarts it.
- R8: In the cycle busy falls, the cleared flag reads 1 and the arm bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded memory-function command is present this cycle |
| cmd_code | input | 8 | Command code; 0x3C requests the clear |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_arm | input | 1 | Value written to the arm bit |
| arm_o | output | 1 | Arm bit as read from the control register |
| cleared_o | output | 1 | Memory-cleared status flag |
| busy_o | output | 1 | Erase run in progress |
| ers_we | output | 1 | Erase port write strobe |
| ers_addr | output | ADDR_W | Erase port address |
| ers_data | output | DATA_W | Erase port write data, always zero |

## Verification
The arm and cleared flags are registered, so each responds one cycle after the control write or command that changes it. Busy rises one cycle after an accepted clear, and the first erase write appears in that same cycle. Busy falls CLR_CYCLES cycles after it rises, and the cleared flag rises on the same edge. The bench drives inputs on the falling edge and samples one falling edge later, so each registered result is read once it has settled. It checks the duration by counting falling edges while busy is high, and it checks each erase write against an address computed from its position in the run.

// File: rtl/mclr_pkg.sv
package mclr_pkg;
  localparam logic [7:0] CMD_CLEAR = 8'h3C;
  localparam int unsigned NUM_REGIONS = 3;
endpackage

// File: rtl/mclr_arm_ctrl.sv
module mclr_arm_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       ctrl_wr,
  input  logic       ctrl_arm,
  input  logic       busy,
  input  logic       done,
  output logic       start,
  output logic       arm_q,
  output logic       cleared_q
);
  import mclr_pkg::*;

  logic arm_n, cleared_n, is_clear;

  assign is_clear = cmd_valid && (cmd_code == CMD_CLEAR);
  assign start    = is_clear && arm_q && !busy;

  always_comb begin
    arm_n = arm_q;
    if (start || busy)   arm_n = 1'b0;
    else if (ctrl_wr)    arm_n = ctrl_arm;
    else if (cmd_valid)  arm_n = 1'b0;
  end

  always_comb begin
    cleared_n = cleared_q;
    if (done)                                       cleared_n = 1'b1;
    else if (ctrl_wr && ctrl_arm && !busy && !start) cleared_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= 1'b0;
      cleared_q <= 1'b0;
    end else begin
      arm_q     <= arm_n;
      cleared_q <= cleared_n;
    end
  end
endmodule

// File: rtl/mclr_erase_seq.sv
module mclr_erase_seq #(
  parameter int unsigned CLR_CYCLES = 40,
  parameter int unsigned NUM_ADDR   = 30,
  localparam int unsigned CNT_W     = $clog2(CLR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy_q,
  output logic             done,
  output logic             we,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(CLR_CYCLES - 1);
  localparam logic [CNT_W-1:0] N_ADDR = CNT_W'(NUM_ADDR);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        done   = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign we  = busy_q && (cnt_q < N_ADDR);
  assign idx = cnt_q;
endmodule

// File: rtl/mclr_addr_map.sv
module mclr_addr_map #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned REG_BASE = 32'h200,
  parameter int unsigned REG_LEN  = 6,
  parameter int unsigned ALM_BASE = 32'h020,
  parameter int unsigned ALM_LEN  = 8,
  parameter int unsigned HIS_BASE = 32'h080,
  parameter int unsigned HIS_LEN  = 16
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  import mclr_pkg::*;

  localparam int unsigned BASES [NUM_REGIONS] = '{REG_BASE, ALM_BASE, HIS_BASE};
  localparam int unsigned LENS  [NUM_REGIONS] = '{REG_LEN, ALM_LEN, HIS_LEN};

  always_comb begin
    int unsigned off;
    logic        hit;
    off  = 0;
    hit  = 1'b0;
    addr = '0;
    for (int r = 0; r < int'(NUM_REGIONS); r++) begin
      if (!hit && (32'(idx) < off + LENS[r])) begin
        addr = ADDR_W'(BASES[r] + 32'(idx) - off);
        hit  = 1'b1;
      end
      off = off + LENS[r];
    end
  end
endmodule

// File: rtl/mission_clear_ctrl.sv
module mission_clear_ctrl #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned REG_BASE   = 32'h200,
  parameter int unsigned REG_LEN    = 6,
  parameter int unsigned ALM_BASE   = 32'h020,
  parameter int unsigned ALM_LEN    = 8,
  parameter int unsigned HIS_BASE   = 32'h080,
  parameter int unsigned HIS_LEN    = 16,
  parameter int unsigned CLR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              ctrl_wr,
  input  logic              ctrl_arm,
  output logic              arm_o,
  output logic              cleared_o,
  output logic              busy_o,
  output logic              ers_we,
  output logic [ADDR_W-1:0] ers_addr,
  output logic [DATA_W-1:0] ers_data
);
  localparam int unsigned NUM_ADDR = REG_LEN + ALM_LEN + HIS_LEN;
  localparam int unsigned CNT_W    = $clog2(CLR_CYCLES + 1);

  logic             start, done;
  logic [CNT_W-1:0] idx;

  mclr_arm_ctrl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .ctrl_wr   (ctrl_wr),
    .ctrl_arm  (ctrl_arm),
    .busy      (busy_o),
    .done      (done),
    .start     (start),
    .arm_q     (arm_o),
    .cleared_q (cleared_o)
  );

  mclr_erase_seq #(
    .CLR_CYCLES (CLR_CYCLES),
    .NUM_ADDR   (NUM_ADDR)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy_q (busy_o),
    .done   (done),
    .we     (ers_we),
    .idx    (idx)
  );

  mclr_addr_map #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (CNT_W),
    .REG_BASE (REG_BASE),
    .REG_LEN  (REG_LEN),
    .ALM_BASE (ALM_BASE),
    .ALM_LEN  (ALM_LEN),
    .HIS_BASE (HIS_BASE),
    .HIS_LEN  (HIS_LEN)
  ) u_map (
    .idx  (idx),
    .addr (ers_addr)
  );

  assign ers_data = '0;
endmodule

// File: rtl/mclr_chk.sv
module mclr_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              ctrl_wr,
  input logic              ctrl_arm,
  input logic              arm_o,
  input logic              cleared_o,
  input logic              busy_o,
  input logic              ers_we,
  input logic [ADDR_W-1:0] ers_addr,
  input logic [DATA_W-1:0] ers_data
);
  import mclr_pkg::*;

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(arm_o) && $past(cmd_valid) && ($past(cmd_code) == CMD_CLEAR))); // R3
  AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !arm_o) |=> !busy_o); // R4
  AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code != CMD_CLEAR) && !ctrl_wr) |=> !arm_o); // R5
  AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_arm && !busy_o && !(cmd_valid && (cmd_code == CMD_CLEAR) && arm_o))
      |=> (arm_o && !cleared_o)); // R2
  AST_BUSY_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !arm_o); // R2
  AST_WE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> busy_o); // R6
  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ers_we |-> (ers_data == '0)); // R6
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (cleared_o && !arm_o)); // R8

  logic unused_addr;
  assign unused_addr = ^ers_addr;
endmodule

bind mission_clear_ctrl mclr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .ctrl_wr   (ctrl_wr),
  .ctrl_arm  (ctrl_arm),
  .arm_o     (arm_o),
  .cleared_o (cleared_o),
  .busy_o    (busy_o),
  .ers_we    (ers_we),
  .ers_addr  (ers_addr),
  .ers_data  (ers_data)
);

// File: tb/mission_clear_ctrl_tb.sv
`timescale 1ns/1ps
module mission_clear_ctrl_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int RB = 'h10, RL = 3;
  localparam int AB = 'h40, AL = 4;
  localparam int HB = 'h80, HL = 5;
  localparam int NCYC = 20;
  localparam int NADDR = RL + AL + HL;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [7:0] cmd_code;
  logic ctrl_wr, ctrl_arm;
  logic arm_o, cleared_o, busy_o, ers_we;
  logic [ADDR_W-1:0] ers_addr;
  logic [DATA_W-1:0] ers_data;

  int total = 0, fails = 0;
  int wr_cnt = 0, mism = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mission_clear_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_BASE(RB), .REG_LEN(RL), .ALM_BASE(AB), .ALM_LEN(AL),
    .HIS_BASE(HB), .HIS_LEN(HL), .CLR_CYCLES(NCYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ctrl_wr(ctrl_wr), .ctrl_arm(ctrl_arm), .arm_o(arm_o), .cleared_o(cleared_o),
    .busy_o(busy_o), .ers_we(ers_we), .ers_addr(ers_addr), .ers_data(ers_data)
  );

  function automatic int exp_addr(int i);
    if (i < RL) return RB + i;
    if (i < RL + AL) return AB + i - RL;
    return HB + i - RL - AL;
  endfunction

  always @(posedge clk) begin
    if (rst_n && ers_we) begin
      if (int'(ers_addr) != exp_addr(wr_cnt) || ers_data != '0) mism++;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle_in();
    cmd_valid = 0; cmd_code = 8'h00; ctrl_wr = 0; ctrl_arm = 0;
  endtask

  task automatic do_arm(input bit v);
    ctrl_wr = 1; ctrl_arm = v; tick(); idle_in();
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_valid = 1; cmd_code = c; tick(); idle_in();
  endtask

  // runs an armed clear; disturb injects stimulus every busy cycle
  task automatic run_clear(input bit disturb);
    int cyc;
    wr_cnt = 0; mism = 0;
    do_cmd(8'h3C);
    chk(busy_o == 1, "R3 busy after clear", busy_o, 1);
    chk(arm_o == 0, "R3 arm after start", arm_o, 0);
    cyc = 0;
    while (busy_o && cyc < 10 * NCYC) begin
      cyc++;
      if (disturb) begin
        case (cyc % 3)
          0: begin ctrl_wr = 1; ctrl_arm = 1; end
          1: begin cmd_valid = 1; cmd_code = 8'h3C; end
          default: begin cmd_valid = 1; cmd_code = 8'(cyc); ctrl_wr = 1; ctrl_arm = 1; end
        endcase
      end
      tick(); idle_in();
      if (disturb && busy_o) chk(arm_o == 0, "R2 arm ignored while busy", arm_o, 0);
    end
    chk(cyc == NCYC, "R7 busy duration", cyc, NCYC);
    chk(wr_cnt == NADDR, "R6 erase write count", wr_cnt, NADDR);
    chk(mism == 0, "R6 erase address/data order", mism, 0);
    chk(cleared_o == 1, "R8 cleared at end", cleared_o, 1);
    chk(arm_o == 0, "R8 arm at end", arm_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 0; idle_in();
    tick(); tick();
    chk(arm_o == 0 && cleared_o == 0, "R1 reset flags", {arm_o, cleared_o}, 0);
    chk(busy_o == 0 && ers_we == 0, "R1 reset busy/we", {busy_o, ers_we}, 0);
    rst_n = 1; tick();

    wr_cnt = 0;
    do_cmd(8'h3C);
    chk(busy_o == 0, "R4 unarmed clear ignored", busy_o, 0);
    tick();
    chk(busy_o == 0 && wr_cnt == 0, "R4 no erase writes", wr_cnt, 0);

    do_arm(1);
    chk(arm_o == 1, "R2 arm set", arm_o, 1);
    do_arm(0);
    chk(arm_o == 0, "R2 arm cleared by write", arm_o, 0);
    do_arm(1);
    run_clear(0);

    do_arm(1);
    chk(cleared_o == 0, "R2 arming clears flag", cleared_o, 1'b0);
    chk(arm_o == 1, "R2 rearm", arm_o, 1);
    do_arm(0);

    for (int c = 0; c < 256; c++) begin
      if (c != 'h3C) begin
        do_arm(1);
        do_cmd(8'(c));
        chk(arm_o == 0, $sformatf("R5 code %0h disarms", c), arm_o, 0);
        do_cmd(8'h3C);
        chk(busy_o == 0, $sformatf("R5 clear after %0h ignored", c), busy_o, 0);
      end
    end

    cmd_valid = 1; cmd_code = 8'h55; ctrl_wr = 1; ctrl_arm = 1; tick(); idle_in();
    chk(arm_o == 1, "R5 control write wins", arm_o, 1);

    run_clear(1);
    do_arm(1);
    chk(cleared_o == 0, "R2 flag cleared after second run", cleared_o, 0);
    run_clear(0);

    tick();
    summary();
  end
endmodule